// File: doc/BRIEF.md
# Tapped Serial Shift Memory

A serial memory of 64 one-bit stages arranged as a single shift chain. A bit presented on the serial input enters the first stage whenever the shift strobe is high at a rising clock edge. On that same edge every other stage takes the value of the stage before it. When the strobe is low, the whole chain keeps its contents.

The first four stages are brought out as early taps. Their drivers are gated by an output enable, and each tap is modelled as a value together with a drive flag. The last stage is brought out as a far-end output that is always driven, whatever the output enable does.

A saturating counter reports how many shifts have happened since reset. It reaches 64 once the far-end output is carrying a bit that came from the serial input. A synchronous active-high reset clears every stage and the counter.

Top module: `tapped_shift_mem`

## Requirements
- R1: A rising edge with `rst` high sets all 64 stages to 0 and sets `shift_cnt` to 0, whatever the other inputs are.
- R2: A rising edge with `shift_en` high (and `rst` low) loads `ser_in` into stage 0. `tap_val[0]` is stage 0.
- R3: On a shift, stage k takes the old value of stage k-1. `tap_val[k]` is stage k, so each tap lags the tap below it by one shift.
- R4: `far_out` is stage 63. A bit shifted in appears on `far_out` after exactly 64 shifts.
- R5: A rising edge with `shift_en` low (and `rst` low) leaves every stage and `shift_cnt` unchanged.
- R6: With `out_en` low, every bit of `tap_drv` is 0 and every bit of `tap_val` reads 0 (high impedance). With `out_en` high, every bit of `tap_drv` is 1 and `tap_val` shows the stage values.
- R7: `far_out` does not depend on `out_en`.
- R8: `shift_cnt` goes up by 1 on each shift and stops at 64. It never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift strobe for the whole chain |
| ser_in | input | 1 | Serial data bit entering stage 0 |
| out_en | input | 1 | Enable for the tap drivers |
| tap_val | output | 4 | Values of stages 0 to 3, or 0 when not driven |
| tap_drv | output | 4 | Drive flag of each tap (1 = driven, 0 = high impedance) |
| far_out | output | 1 | Value of stage 63, always driven |
| shift_cnt | output | 7 | Number of shifts since reset, saturating at 64 |

## Verification
The tap-lag property assumes that `out_en` is high in both cycles it compares. The hold and counter properties assume that `rst` was low at the edge in question. The properties therefore say nothing about cycles where the enable changes or reset is applied, and the bench deliberately toggles `out_en` and pulses reset in the middle of a run to cover those windows. Stimulus is random, but it is always driven on the falling edge, so every input is stable around each rising edge.

// File: rtl/tapped_shift_mem.sv
module tapped_shift_mem #(
  parameter int DEPTH = 64,
  parameter int TAPS  = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            ser_in,
  input  logic            out_en,
  output logic [TAPS-1:0] tap_val,
  output logic [TAPS-1:0] tap_drv,
  output logic            far_out,
  output logic [CW-1:0]   shift_cnt
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst)           stage[0] <= 1'b0;
    else if (shift_en) stage[0] <= ser_in;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           stage[k] <= 1'b0;
      else if (shift_en) stage[k] <= stage[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               shift_cnt <= '0;
    else if (shift_en && shift_cnt != FULL) shift_cnt <= shift_cnt + 1'b1;
  end

  assign tap_drv = {TAPS{out_en}};
  assign tap_val = stage[TAPS-1:0] & tap_drv;
  assign far_out = stage[DEPTH-1];

endmodule

// File: rtl/tapped_shift_mem_chk.sv
module tapped_shift_mem_chk #(
  parameter int DEPTH = 64,
  parameter int TAPS  = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            shift_en,
  input logic            out_en,
  input logic [TAPS-1:0] tap_val,
  input logic [TAPS-1:0] tap_drv,
  input logic            far_out,
  input logic [CW-1:0]   shift_cnt
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (shift_cnt == '0 && far_out == 1'b0 && tap_val == '0));

  for (genvar k = 1; k < TAPS; k++) begin : g_lag
    // R3
    tap_lag_chk: assert property (@(posedge clk) disable iff (rst)
      (shift_en && out_en) |=> (!out_en || tap_val[k] == $past(tap_val[k-1])));
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(far_out) && $stable(shift_cnt)));

  // R6
  drv_off_chk: assert property (@(posedge clk)
    !out_en |-> (tap_drv == '0 && tap_val == '0));

  // R6
  drv_on_chk: assert property (@(posedge clk)
    out_en |-> (&tap_drv));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_cnt != FULL) |=> (shift_cnt == $past(shift_cnt) + 1'b1));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    shift_cnt <= FULL);

endmodule

bind tapped_shift_mem tapped_shift_mem_chk #(.DEPTH(DEPTH), .TAPS(TAPS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .out_en(out_en),
  .tap_val(tap_val), .tap_drv(tap_drv), .far_out(far_out), .shift_cnt(shift_cnt)
);

// File: tb/tb_tapped_shift_mem.sv
module tb_tapped_shift_mem;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic out_en = 1'b0;
  logic [3:0] tap_val;
  logic [3:0] tap_drv;
  logic far_out;
  logic [6:0] shift_cnt;

  int compared = 0;
  int mismatched = 0;
  bit ref_q[$];
  int ref_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tapped_shift_mem dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .out_en(out_en),
    .tap_val(tap_val), .tap_drv(tap_drv), .far_out(far_out), .shift_cnt(shift_cnt)
  );

  task automatic chk(string tag, string phase, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  task automatic step(bit r, bit sh, bit d, bit oe, string phase);
    rst = r; shift_en = sh; ser_in = d; out_en = oe;
    @(posedge clk);
    if (r) begin
      ref_q.delete();
      for (int i = 0; i < 64; i++) ref_q.push_back(1'b0);
      ref_cnt = 0;
    end else if (sh) begin
      ref_q.push_front(d);
      void'(ref_q.pop_back());
      if (ref_cnt < 64) ref_cnt++;
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(i == 0 ? "R2 tap0" : "R3 tap", phase, int'(tap_val[i]), oe ? int'(ref_q[i]) : 0);
      chk("R6 drive", phase, int'(tap_drv[i]), int'(oe));
    end
    chk("R4 R7 far", phase, int'(far_out), int'(ref_q[63]));
    chk("R8 count", phase, int'(shift_cnt), ref_cnt);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_q.push_back(1'b0);
    @(negedge clk);
    // R1 reset state, with out_en both ways
    step(1, 1, 1, 1, "R1 reset");
    step(1, 0, 1, 0, "R1 reset");
    // R2 R3 R4 fill chain, taps enabled
    for (int i = 0; i < 70; i++) step(0, 1, 1'($urandom), 1, "R4 fill");
    // R5 hold with data wiggling
    for (int i = 0; i < 20; i++) step(0, 0, 1'($urandom), 1'($urandom), "R5 hold");
    // R6 R7 taps off while shifting
    for (int i = 0; i < 30; i++) step(0, 1, 1'($urandom), 0, "R7 oe-off");
    // mixed traffic
    for (int i = 0; i < 300; i++)
      step(0, 1'($urandom), 1'($urandom), 1'($urandom), "mixed");
    // R1 mid-run reset then R8 saturation
    step(1, 1, 1, 1, "R1 mid reset");
    for (int i = 0; i < 63; i++) step(0, 1, 1, 1, "R8 ramp");
    step(0, 0, 0, 1, "R8 before 64");
    step(0, 1, 1, 1, "R8 at 64");
    for (int i = 0; i < 80; i++) step(0, 1, 1'($urandom), 1'($urandom), "R8 saturate");
    // alternating pattern to see lag on taps
    for (int i = 0; i < 40; i++) step(0, 1, 1'(i % 2), 1, "R3 alternate");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule